// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction in the execute slot with the destination numbers held further down the pipe. From that it picks the input for each ALU operand multiplexer: the register file value, the result waiting in the memory-stage register, or the value waiting in the writeback-stage register. When both later stages write the same register, the younger result in the memory stage is used.

It also watches for a load in the execute slot whose destination is read by the instruction in decode. Forwarding cannot help here, because the loaded data only exists at the end of the memory stage. In that case the block holds the program counter and the fetch/decode register for one cycle, and it clears the control bits entering the execute slot so that the slot becomes a no-op. A small internal flag makes sure that a single hazard never produces more than one stall cycle. Register 0 reads as zero, so it never forwards and never stalls.

Top module: `fwd_stall_unit`

## Requirements
- R1: When `memRegWrite` is 1, `memRd` is nonzero and equals an execute-slot source (`exRs1` for operand A, `exRs2` for operand B), that operand's select is 2'b10 (take the memory-stage result). Each operand is decided on its own.
- R2: When no memory-stage match applies, `wbRegWrite` is 1, and `wbRd` is nonzero and equals the source, the select is 2'b01 (take the writeback-stage value).
- R3: When both the memory stage and the writeback stage qualify for the same source, the select is 2'b10.
- R4: A source or destination number of 0 never gives a nonzero select and never raises the stall outputs.
- R5: A stage whose write enable is 0 does not forward, even when its destination matches the source.
- R6: With no qualifying match the select is 2'b00 (register file). This covers a producer three or more instructions older, which has already left the writeback register.
- R7: When `exMemRead` is 1, `exRd` is nonzero and equals `idRs1` or `idRs2`, and no stall was raised in the previous cycle, `pcHold`, `ifIdHold` and `idExBubble` are all 1 in that same cycle.
- R8: A stall lasts exactly one cycle: in the cycle right after a stall the three stall outputs are 0, even if the hazard inputs still match.
- R9: A producer in the execute slot that is not a load (`exMemRead` 0) never raises the stall outputs.
- R10: The three stall outputs always carry the same value, and after reset they are 0 while no load hazard is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idRs1 | input | AW | First source register of the instruction in decode |
| idRs2 | input | AW | Second source register of the instruction in decode |
| exRs1 | input | AW | First source register in the execute slot |
| exRs2 | input | AW | Second source register in the execute slot |
| exRd | input | AW | Destination register in the execute slot |
| exMemRead | input | 1 | Instruction in the execute slot is a load |
| memRd | input | AW | Destination held in the memory-stage register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | AW | Destination held in the writeback-stage register |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| fwdSelA | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory stage |
| fwdSelB | output | 2 | Operand B select, same encoding |
| pcHold | output | 1 | Hold the program counter |
| ifIdHold | output | 1 | Hold the fetch/decode register |
| idExBubble | output | 1 | Clear the control bits entering the execute slot |

## Verification
Forwarding is tried with a match on operand A only, on operand B only, with the writeback stage alone, and with both stages naming the same register. Together these separate a swapped priority and crossed operands from correct behaviour. Register 0 destinations, disabled write enables and an old producer check that no select is raised on a bare number match. The interlock is tried with the load destination matching each decode source, held for three cycles to expose a stall that repeats or never ends, and then with a non-load producer to show that the memory-read flag gates the stall.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  parameter int unsigned REG_AW = 5;
  localparam int unsigned N_SRC = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opndSel_e;

  typedef struct packed {
    logic pcHold;
    logic ifIdHold;
    logic idExBubble;
  } stallStrobes_t;
endpackage

// File: rtl/fsu_fwd_path.sv
module fsu_fwd_path
  import fsu_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [N_SRC-1:0][AW-1:0] exSrc,
  input  logic [N_SRC-1:0][AW-1:0] idSrc,
  input  logic [AW-1:0]            exRd,
  input  logic                     exMemRead,
  input  logic [AW-1:0]            memRd,
  input  logic                     memWe,
  input  logic [AW-1:0]            wbRd,
  input  logic                     wbWe,
  output logic [N_SRC-1:0][1:0]    selOut,
  output logic                     loadUseHit
);
  logic memLive;
  logic wbLive;
  logic [N_SRC-1:0] useHit;

  // a stage only offers a value when it writes a real register
  assign memLive = memWe && (memRd != '0);
  assign wbLive  = wbWe && (wbRd != '0);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic memHit;
    logic wbHit;
    assign memHit = memLive && (memRd == exSrc[g]);
    assign wbHit  = wbLive && (wbRd == exSrc[g]);

    // younger result (memory stage) wins over writeback
    always_comb begin
      if (memHit)     selOut[g] = SEL_MEM;
      else if (wbHit) selOut[g] = SEL_WB;
      else            selOut[g] = SEL_RF;
    end

    assign useHit[g] = (exRd == idSrc[g]);
  end

  assign loadUseHit = exMemRead && (exRd != '0) && (|useHit);
endmodule

// File: rtl/fsu_stall_ctl.sv
module fsu_stall_ctl
  import fsu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loadUseHit,
  output stallStrobes_t strobes
);
  logic stallNow;
  logic stallPrev;

  // one bubble per hazard: once the stall cycle is spent, the load has moved on
  assign stallNow = loadUseHit && !stallPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stallPrev <= 1'b0;
    else        stallPrev <= stallNow;
  end

  always_comb begin
    strobes.pcHold     = stallNow;
    strobes.ifIdHold   = stallNow;
    strobes.idExBubble = stallNow;
  end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import fsu_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [AW-1:0] exRs1,
  input  logic [AW-1:0] exRs2,
  input  logic [AW-1:0] exRd,
  input  logic          exMemRead,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          pcHold,
  output logic          ifIdHold,
  output logic          idExBubble
);
  logic [N_SRC-1:0][AW-1:0] exSrc;
  logic [N_SRC-1:0][AW-1:0] idSrc;
  logic [N_SRC-1:0][1:0]    selVec;
  logic                     loadUseHit;
  stallStrobes_t            strobes;

  assign exSrc = {exRs2, exRs1};
  assign idSrc = {idRs2, idRs1};

  fsu_fwd_path #(.AW(AW)) u_path (
    .exSrc      (exSrc),
    .idSrc      (idSrc),
    .exRd       (exRd),
    .exMemRead  (exMemRead),
    .memRd      (memRd),
    .memWe      (memRegWrite),
    .wbRd       (wbRd),
    .wbWe       (wbRegWrite),
    .selOut     (selVec),
    .loadUseHit (loadUseHit)
  );

  fsu_stall_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .loadUseHit (loadUseHit),
    .strobes    (strobes)
  );

  assign fwdSelA    = selVec[0];
  assign fwdSelB    = selVec[1];
  assign pcHold     = strobes.pcHold;
  assign ifIdHold   = strobes.ifIdHold;
  assign idExBubble = strobes.idExBubble;
endmodule

// File: rtl/fwd_stall_unit_chk.sv
module fwd_stall_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] idRs1,
  input logic [AW-1:0] idRs2,
  input logic [AW-1:0] exRs1,
  input logic [AW-1:0] exRs2,
  input logic [AW-1:0] exRd,
  input logic          exMemRead,
  input logic [AW-1:0] memRd,
  input logic          memRegWrite,
  input logic [AW-1:0] wbRd,
  input logic          wbRegWrite,
  input logic [1:0]    fwdSelA,
  input logic [1:0]    fwdSelB,
  input logic          pcHold,
  input logic          ifIdHold,
  input logic          idExBubble
);
  a_r1_mem_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
    (memRegWrite && memRd != '0 && memRd == exRs1) |-> fwdSelA == 2'b10);

  a_r3_mem_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
    (memRegWrite && memRd != '0 && memRd == exRs2 && wbRegWrite && wbRd == exRs2)
      |-> fwdSelB == 2'b10);

  a_r2_wb_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wbRegWrite && wbRd != '0 && wbRd == exRs1 && !(memRegWrite && memRd == exRs1))
      |-> fwdSelA == 2'b01);

  a_r4_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (exRs1 == '0) |-> fwdSelA == 2'b00);

  a_r5_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!memRegWrite && !wbRegWrite) |-> (fwdSelA == 2'b00 && fwdSelB == 2'b00));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pcHold |=> !pcHold);

  a_r9_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    !exMemRead |-> !pcHold);

  a_r10_strobes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pcHold == ifIdHold) && (ifIdHold == idExBubble));
endmodule

bind fwd_stall_unit fwd_stall_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idRs1(idRs1), .idRs2(idRs2),
  .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exMemRead(exMemRead),
  .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
  .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .pcHold(pcHold),
  .ifIdHold(ifIdHold), .idExBubble(idExBubble)
);

// File: tb/fwd_stall_unit_tb.sv
module fwd_stall_unit_tb;
  localparam int CLK_P = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] idRs1, idRs2, exRs1, exRs2, exRd;
    logic          exLoad;
    logic [AW-1:0] memRd;
    logic          memWe;
    logic [AW-1:0] wbRd;
    logic          wbWe;
  } stim_t;

  typedef struct {
    logic [1:0] selA;
    logic [1:0] selB;
    logic       stall;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t cur = '0;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcHold, ifIdHold, idExBubble;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic prevStall = 1'b0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fwd_stall_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .idRs1(cur.idRs1), .idRs2(cur.idRs2),
    .exRs1(cur.exRs1), .exRs2(cur.exRs2), .exRd(cur.exRd),
    .exMemRead(cur.exLoad), .memRd(cur.memRd), .memRegWrite(cur.memWe),
    .wbRd(cur.wbRd), .wbRegWrite(cur.wbWe),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .pcHold(pcHold), .ifIdHold(ifIdHold), .idExBubble(idExBubble)
  );

  // expected select from R1..R6
  function automatic logic [1:0] expSel(logic [AW-1:0] rs, stim_t s);
    if (rs != '0 && s.memWe && s.memRd == rs) return 2'b10;
    if (rs != '0 && s.wbWe && s.wbRd == rs) return 2'b01;
    return 2'b00;
  endfunction

  task automatic driveStep(stim_t s, string tag);
    exp_t e;
    logic lu;
    @(negedge clk);
    cur = s;
    lu = s.exLoad && s.exRd != '0 && (s.exRd == s.idRs1 || s.exRd == s.idRs2);
    e.selA = expSel(s.exRs1, s);
    e.selB = expSel(s.exRs2, s);
    e.stall = lu && !prevStall;   // R7 / R8
    e.tag = tag;
    prevStall = e.stall;
    q.push_back(e);
  endtask

  // monitor: samples a quarter period after inputs change
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (fwdSelA !== e.selA || fwdSelB !== e.selB || pcHold !== e.stall ||
            ifIdHold !== e.stall || idExBubble !== e.stall) begin
          bad++;
          $display("FAIL %s: got selA=%b selB=%b hold=%b/%b/%b exp selA=%b selB=%b stall=%b",
                   e.tag, fwdSelA, fwdSelB, pcHold, ifIdHold, idExBubble,
                   e.selA, e.selB, e.stall);
        end
      end
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    s = '0; driveStep(s, "R10 idle after reset");
    s = '0; s.exRs1 = 3; s.exRs2 = 4; s.memRd = 3; s.memWe = 1;
    driveStep(s, "R1 mem-stage forward to operand A");
    s = '0; s.exRs1 = 6; s.exRs2 = 7; s.memRd = 7; s.memWe = 1;
    driveStep(s, "R1 mem-stage forward to operand B");
    s = '0; s.exRs1 = 9; s.exRs2 = 2; s.wbRd = 9; s.wbWe = 1; s.memRd = 5; s.memWe = 1;
    driveStep(s, "R2 writeback forward to operand A");
    s = '0; s.exRs1 = 1; s.exRs2 = 12; s.memRd = 12; s.memWe = 1; s.wbRd = 12; s.wbWe = 1;
    driveStep(s, "R3 younger result wins on operand B");
    s = '0; s.exRs1 = 0; s.exRs2 = 0; s.memRd = 0; s.memWe = 1; s.wbRd = 0; s.wbWe = 1;
    s.exLoad = 1; s.exRd = 0;
    driveStep(s, "R4 register zero neither forwards nor stalls");
    s = '0; s.exRs1 = 8; s.exRs2 = 8; s.memRd = 8; s.memWe = 0; s.wbRd = 8; s.wbWe = 1;
    driveStep(s, "R5 disabled mem stage falls through to writeback");
    s = '0; s.exRs1 = 8; s.exRs2 = 10; s.memRd = 8; s.wbRd = 10;
    driveStep(s, "R5 both enables low means no forward");
    s = '0; s.exRs1 = 14; s.exRs2 = 15; s.memRd = 16; s.memWe = 1; s.wbRd = 17; s.wbWe = 1;
    driveStep(s, "R6 producer already retired uses register file");
    s = '0; s.exLoad = 1; s.exRd = 11; s.idRs1 = 11; s.idRs2 = 2;
    driveStep(s, "R7 load-use on first decode source");
    driveStep(s, "R8 no second stall cycle");
    driveStep(s, "R8 guard released after one clear cycle");
    s = '0; driveStep(s, "R10 idle between hazards");
    s = '0; s.exLoad = 1; s.exRd = 20; s.idRs1 = 3; s.idRs2 = 20;
    driveStep(s, "R7 load-use on second decode source");
    s = '0; driveStep(s, "R8 stall drops when hazard gone");
    s = '0; s.exLoad = 0; s.exRd = 21; s.idRs1 = 21; s.idRs2 = 21;
    driveStep(s, "R9 non-load producer never stalls");
    s = '0; s.exLoad = 1; s.exRd = 22; s.idRs1 = 23; s.idRs2 = 24;
    driveStep(s, "R9 load without a reader does not stall");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #(CLK_P * 2000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: got %0d pending exp 0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule